// File: doc/BRIEF.md
# Mixed-Signedness Byte Matrix Multiply-Accumulate

This block takes two packed byte matrices and a packed 2x2 accumulator. It returns the accumulator with the matrix product added to it. Operand A is a 2-row by 8-column matrix of 8-bit values. Operand B is an 8-row by 2-column matrix of 8-bit values. Each of the four 32-bit result lanes is its accumulator lane plus an 8-term dot product of one row of A with one column of B.

A 2-bit mode input sets the signedness of each operand on its own, so the block covers signed-by-signed, unsigned-by-unsigned and unsigned-by-signed. The fourth code is rejected: the block raises a flag and returns the accumulator unchanged.

Each operation is framed by a valid/ready handshake on the input side and on the output side, and the result is registered.

Top module: `mixsign_mmacc`

## Requirements
- R1: Bytes 0-7 of `opnd_a` form row 0 of A and bytes 8-15 form row 1. Bytes 0-7 of `opnd_b` form column 0 of B and bytes 8-15 form column 1. Byte k of a row or column is dot-product term k. Result lane index is row*2+column, and lane 0 sits in bits 31:0.
- R2: Each result lane equals its `acc_in` lane plus the 8-term dot product. The sum wraps modulo 2^32 and never saturates.
- R3: Mode 2'b00 treats both operands as signed two's complement bytes.
- R4: Mode 2'b01 treats both operands as unsigned bytes.
- R5: Mode 2'b10 treats A as unsigned and B as signed.
- R6: Mode 2'b11 sets `bad_mode` and returns `acc_out` equal to the accepted `acc_in`.
- R7: An accepted operation with a legal mode returns `bad_mode` low.
- R8: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result and flag appear with `out_valid` after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `acc_out`, `bad_mode` and `out_valid` hold, and `in_ready` is low.
- R10: A synchronous active-high `rst` clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can take an operation |
| mode | input | 2 | Signedness select (00 s*s, 01 u*u, 10 u*s, 11 illegal) |
| opnd_a | input | 128 | Matrix A, 2 rows of 8 bytes |
| opnd_b | input | 128 | Matrix B, 2 columns of 8 bytes |
| acc_in | input | 128 | Accumulator, four 32-bit lanes |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| acc_out | output | 128 | Updated accumulator |
| bad_mode | output | 1 | Accepted operation had the illegal mode |

## Verification
Directed byte patterns built from 0, 127, 0x80 and 0xFF, run in every mode, tell the three signedness treatments apart. The same byte reads as 128 or -128 depending on the mode, so a wrong extension shows up as a different lane value. A single nonzero byte in each operand lights exactly one lane, which pins down the row, column and term ordering. An all-ones accumulator added to a large unsigned product exercises the wrap. Seeded random operands over all four codes, together with a held-back consumer, cover the illegal-mode path and the stalled output.

// File: rtl/mixsign_mmacc_pkg.sv
package mixsign_mmacc_pkg;
   typedef enum logic [1:0] {
      MM_SS  = 2'b00,
      MM_UU  = 2'b01,
      MM_US  = 2'b10,
      MM_BAD = 2'b11
   } mm_mode_e;

   function automatic logic mode_a_signed(input logic [1:0] m);
      return m == MM_SS;
   endfunction

   function automatic logic mode_b_signed(input logic [1:0] m);
      return (m == MM_SS) || (m == MM_US);
   endfunction

   function automatic logic mode_illegal(input logic [1:0] m);
      return m == MM_BAD;
   endfunction
endpackage

// File: rtl/mm_byte_ext.sv
module mm_byte_ext #(
   parameter int ELEM_W = 8,
   parameter int OUT_W  = 32,
   parameter int N      = 8
) (
   input  logic [N*ELEM_W-1:0] raw,
   input  logic                is_signed,
   output logic [N*OUT_W-1:0]  ext
);
   localparam int PAD_W = OUT_W - ELEM_W;

   if (PAD_W < 1) begin : g_bad_width
      $error("mm_byte_ext: OUT_W must exceed ELEM_W");
   end

   for (genvar i = 0; i < N; i++) begin : g_elem
      logic [ELEM_W-1:0] e;
      logic              fill;
      assign e    = raw[i*ELEM_W +: ELEM_W];
      assign fill = is_signed & e[ELEM_W-1];
      assign ext[i*OUT_W +: OUT_W] = {{PAD_W{fill}}, e};
   end
endmodule

// File: rtl/mm_dot_lane.sv
module mm_dot_lane #(
   parameter int  ACC_W    = 32,
   parameter int  DEPTH    = 8,
   parameter bit  USE_TREE = 1'b1
) (
   input  logic [DEPTH*ACC_W-1:0] row_v,
   input  logic [DEPTH*ACC_W-1:0] col_v,
   input  logic [ACC_W-1:0]       acc_lane,
   output logic [ACC_W-1:0]       sum_lane
);
   localparam int LEVELS = $clog2(DEPTH);

   logic [ACC_W-1:0] prod [DEPTH];
   logic [ACC_W-1:0] dot;

   for (genvar k = 0; k < DEPTH; k++) begin : g_mul
      assign prod[k] = ACC_W'(row_v[k*ACC_W +: ACC_W] * col_v[k*ACC_W +: ACC_W]);
   end

   if (USE_TREE) begin : g_tree
      if ((1 << LEVELS) != DEPTH) begin : g_bad_depth
         $error("mm_dot_lane: tree adder needs DEPTH a power of two");
      end
      for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
         logic [ACC_W-1:0] v [DEPTH >> l];
         if (l == 0) begin : g_leaf
            for (genvar i = 0; i < DEPTH; i++) begin : g_n
               assign v[i] = prod[i];
            end
         end else begin : g_node
            for (genvar i = 0; i < (DEPTH >> l); i++) begin : g_n
               assign v[i] = g_lvl[l-1].v[2*i] + g_lvl[l-1].v[2*i+1];
            end
         end
      end
      assign dot = g_lvl[LEVELS].v[0];
   end else begin : g_chain
      always_comb begin
         dot = '0;
         for (int k = 0; k < DEPTH; k++) dot = dot + prod[k];
      end
   end

   assign sum_lane = acc_lane + dot;
endmodule

// File: rtl/mm_out_reg.sv
module mm_out_reg #(
   parameter int DW = 128
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          take,
   input  logic [DW-1:0] d_data,
   input  logic          d_flag,
   input  logic          out_ready,
   output logic          out_valid,
   output logic [DW-1:0] q_data,
   output logic          q_flag
);
   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else if (take) begin
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (take) begin
         q_data <= d_data;
         q_flag <= d_flag;
      end
   end
endmodule

// File: rtl/mixsign_mmacc.sv
module mixsign_mmacc #(
   parameter int ELEM_W   = 8,
   parameter int DEPTH    = 8,
   parameter int ACC_W    = 32,
   parameter bit USE_TREE = 1'b1,
   localparam int ROWS    = 2,
   localparam int COLS    = 2,
   localparam int VEC_W   = DEPTH * ELEM_W,
   localparam int A_W     = ROWS * VEC_W,
   localparam int B_W     = COLS * VEC_W,
   localparam int R_W     = ROWS * COLS * ACC_W
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [1:0]     mode,
   input  logic [A_W-1:0] opnd_a,
   input  logic [B_W-1:0] opnd_b,
   input  logic [R_W-1:0] acc_in,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [R_W-1:0] acc_out,
   output logic           bad_mode
);
   import mixsign_mmacc_pkg::*;

   localparam int MIN_ACC = 2 * ELEM_W + 1 + $clog2(DEPTH);

   if (ACC_W < MIN_ACC) begin : g_bad_acc
      $error("mixsign_mmacc: ACC_W too narrow for one dot product");
   end

   logic             a_sgn, b_sgn, illegal, take;
   logic [R_W-1:0]   lanes, next_acc;
   logic [DEPTH*ACC_W-1:0] row_x [ROWS];
   logic [DEPTH*ACC_W-1:0] col_x [COLS];

   assign a_sgn   = mode_a_signed(mode);
   assign b_sgn   = mode_b_signed(mode);
   assign illegal = mode_illegal(mode);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      mm_byte_ext #(.ELEM_W(ELEM_W), .OUT_W(ACC_W), .N(DEPTH)) u_ext (
         .raw       (opnd_a[r*VEC_W +: VEC_W]),
         .is_signed (a_sgn),
         .ext       (row_x[r])
      );
   end

   for (genvar c = 0; c < COLS; c++) begin : g_col
      mm_byte_ext #(.ELEM_W(ELEM_W), .OUT_W(ACC_W), .N(DEPTH)) u_ext (
         .raw       (opnd_b[c*VEC_W +: VEC_W]),
         .is_signed (b_sgn),
         .ext       (col_x[c])
      );
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_lr
      for (genvar c = 0; c < COLS; c++) begin : g_lc
         localparam int LANE = r * COLS + c;
         mm_dot_lane #(.ACC_W(ACC_W), .DEPTH(DEPTH), .USE_TREE(USE_TREE)) u_lane (
            .row_v    (row_x[r]),
            .col_v    (col_x[c]),
            .acc_lane (acc_in[LANE*ACC_W +: ACC_W]),
            .sum_lane (lanes[LANE*ACC_W +: ACC_W])
         );
      end
   end

   assign next_acc = illegal ? acc_in : lanes;
   assign in_ready = ~out_valid | out_ready;
   assign take     = in_valid & in_ready;

   mm_out_reg #(.DW(R_W)) u_out (
      .clk       (clk),
      .rst       (rst),
      .take      (take),
      .d_data    (next_acc),
      .d_flag    (illegal),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .q_data    (acc_out),
      .q_flag    (bad_mode)
   );
endmodule

// File: rtl/mixsign_mmacc_chk.sv
module mixsign_mmacc_chk #(
   parameter int A_W = 128,
   parameter int B_W = 128,
   parameter int R_W = 128
) (
   input logic           clk,
   input logic           rst,
   input logic           in_valid,
   input logic           in_ready,
   input logic [1:0]     mode,
   input logic [A_W-1:0] opnd_a,
   input logic [B_W-1:0] opnd_b,
   input logic [R_W-1:0] acc_in,
   input logic           out_valid,
   input logic           out_ready,
   input logic [R_W-1:0] acc_out,
   input logic           bad_mode
);
   logic acc_ok;
   assign acc_ok = in_valid & in_ready;

   // R10
   p_reset_clears_r10: assert property (@(posedge clk) rst |=> !out_valid);

   // R8
   p_accept_gives_valid_r8: assert property (@(posedge clk) disable iff (rst)
      acc_ok |=> out_valid);

   // R9
   p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(acc_out) && $stable(bad_mode)));

   // R9
   p_stall_blocks_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   // R6
   p_illegal_passes_r6: assert property (@(posedge clk) disable iff (rst)
      (acc_ok && mode == 2'b11) |=> (bad_mode && acc_out == $past(acc_in)));

   // R7
   p_legal_no_flag_r7: assert property (@(posedge clk) disable iff (rst)
      (acc_ok && mode != 2'b11) |=> !bad_mode);

   // R2
   p_zero_a_keeps_acc_r2: assert property (@(posedge clk) disable iff (rst)
      (acc_ok && opnd_a == '0) |=> (acc_out == $past(acc_in)));
endmodule

bind mixsign_mmacc mixsign_mmacc_chk #(.A_W(A_W), .B_W(B_W), .R_W(R_W)) u_chk (.*);

// File: tb/mixsign_mmacc_bench.sv
`timescale 1ns/1ps
module mixsign_mmacc_bench;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [1:0]   mode = 2'b00;
   logic [127:0] opnd_a = '0, opnd_b = '0, acc_in = '0;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] acc_out;
   logic         bad_mode;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   mixsign_mmacc u_mixsign_mmacc (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .mode(mode), .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_in(acc_in),
      .out_valid(out_valid), .out_ready(out_ready), .acc_out(acc_out),
      .bad_mode(bad_mode)
   );

   function automatic longint byte_val(input logic [7:0] b, input bit sgn);
      longint v = longint'(b);
      if (sgn && v > 127) v = v - 256;
      return v;
   endfunction

   function automatic logic [127:0] model(input logic [1:0] md,
         input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc);
      logic [127:0] res;
      bit sa = (md == 2'b00);
      bit sb = (md == 2'b00) || (md == 2'b10);
      if (md == 2'b11) return acc;
      for (int r = 0; r < 2; r++) begin
         for (int c = 0; c < 2; c++) begin
            longint s = 0;
            logic [31:0] t;
            for (int k = 0; k < 8; k++)
               s += byte_val(a[(r*8+k)*8 +: 8], sa) * byte_val(b[(c*8+k)*8 +: 8], sb);
            t = acc[(r*2+c)*32 +: 32] + s[31:0];
            res[(r*2+c)*32 +: 32] = t;
         end
      end
      return res;
   endfunction

   task automatic check(input bit ok, input string req, input logic [127:0] act,
                        input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic string mode_req(input logic [1:0] md);
      case (md)
         2'b00: return "R3";
         2'b01: return "R4";
         2'b10: return "R5";
         default: return "R6";
      endcase
   endfunction

   // one operation, consumer ready; checks R2/R8 and the mode requirement
   task automatic run_op(input logic [1:0] md, input logic [127:0] a,
                         input logic [127:0] b, input logic [127:0] acc);
      logic [127:0] exp;
      exp = model(md, a, b, acc);
      @(negedge clk);
      mode = md; opnd_a = a; opnd_b = b; acc_in = acc; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid === 1'b1, "R8", {127'd0, out_valid}, 128'd1);
      check(acc_out === exp, mode_req(md), acc_out, exp);
      check(bad_mode === (md == 2'b11), (md == 2'b11) ? "R6" : "R7",
            {127'd0, bad_mode}, {127'd0, md == 2'b11});
   endtask

   function automatic logic [127:0] fill(input logic [7:0] b);
      return {16{b}};
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] corners [4];
      logic [127:0] exp;
      void'($urandom(32'd1234));
      corners[0] = 8'h00; corners[1] = 8'h7F; corners[2] = 8'h80; corners[3] = 8'hFF;

      repeat (3) @(negedge clk);
      check(out_valid === 1'b0, "R10", {127'd0, out_valid}, 128'd0);
      check(in_ready === 1'b1, "R10", {127'd0, in_ready}, 128'd1);
      rst = 1'b0;

      // R1: single nonzero byte, A byte 9 (row1,k1)=2, B byte 1 (col0,k1)=3 -> lane 2 = 6
      begin
         logic [127:0] a1 = '0, b1 = '0;
         a1[9*8 +: 8] = 8'd2;
         b1[1*8 +: 8] = 8'd3;
         run_op(2'b01, a1, b1, '0);
         check(acc_out === {32'd0, 32'd6, 32'd0, 32'd0}, "R1", acc_out,
               {32'd0, 32'd6, 32'd0, 32'd0});
      end
      // R1: A byte 3 (row0) and B byte 12 (col1, k4) do not meet -> all zero
      begin
         logic [127:0] a1 = '0, b1 = '0;
         a1[3*8 +: 8]  = 8'd5;
         b1[12*8 +: 8] = 8'd7;
         run_op(2'b01, a1, b1, '0);
         check(acc_out === '0, "R1", acc_out, '0);
      end

      // R2 wrap: all-ones acc plus 8*255*255 in mode 01 -> 0x0007F007 per lane
      run_op(2'b01, fill(8'hFF), fill(8'hFF), {4{32'hFFFF_FFFF}});
      check(acc_out[31:0] === 32'h0007_F007, "R2", {96'd0, acc_out[31:0]}, 128'h7F007);

      // R3/R4/R5: 0xFF times 0xFF: signed 8, unsigned 520200, mixed -2040 per lane
      run_op(2'b00, fill(8'hFF), fill(8'hFF), '0);
      check(acc_out[31:0] === 32'd8, "R3", acc_out, 128'd8);
      run_op(2'b10, fill(8'hFF), fill(8'hFF), '0);
      check(acc_out[31:0] === 32'hFFFF_F808, "R5", acc_out, 128'hFFFFF808);

      // corners in every mode
      for (int m = 0; m < 4; m++)
         for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
               run_op(2'(m), fill(corners[i]), fill(corners[j]),
                      {$urandom, $urandom, $urandom, $urandom});

      // R9: stall consumer
      exp = model(2'b00, fill(8'h80), fill(8'h7F), '0);
      @(negedge clk);
      out_ready = 1'b0;
      mode = 2'b00; opnd_a = fill(8'h80); opnd_b = fill(8'h7F); acc_in = '0;
      in_valid = 1'b1;
      @(negedge clk);
      opnd_a = fill(8'h01); mode = 2'b11;
      for (int s = 0; s < 3; s++) begin
         check(in_ready === 1'b0, "R9", {127'd0, in_ready}, 128'd0);
         check(out_valid === 1'b1 && acc_out === exp && bad_mode === 1'b0, "R9",
               acc_out, exp);
         @(negedge clk);
      end
      in_valid = 1'b0;
      out_ready = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "R8", {127'd0, out_valid}, 128'd0);

      // random
      for (int n = 0; n < 300; n++)
         run_op(2'($urandom), {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom},
                {$urandom, $urandom, $urandom, $urandom});

      // R10: reset while holding a result
      @(negedge clk);
      out_ready = 1'b0;
      mode = 2'b01; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "R10", {127'd0, out_valid}, 128'd0);
      rst = 1'b0; out_ready = 1'b1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule